// File: doc/BRIEF.md
# I2C Shared-Bus Condition Monitor

This block listens to the clock and data lines of an I2C bus on which several masters compete. It runs both lines through a synchroniser and recognises START, repeated START and STOP conditions. From them it keeps a small bus-state machine with sticky "start seen" and "stop seen" status. The local master reads a bus-free indication from this status before it tries to take the bus.

While the local master is in one of its active bus phases, the block compares the SDA level it samples on each SCL rising edge with the level the master means to leave on the line. A lost arbitration sets a sticky collision flag and records the phase in which it happened. A single interrupt flag gathers the bus events of interest. It is gated by an interrupt enable and both flags are cleared by one-cycle clear strobes.

The state machine has four states. `ST_IDLE` means neither START nor STOP has been seen. `ST_HELD` means a START was seen. `ST_RESTART` means a repeated START was seen. `ST_FREED` means a STOP was seen. Its transitions are:
- On a START, `ST_IDLE` and `ST_FREED` go to `ST_HELD`.
- On a START, `ST_HELD` goes to `ST_RESTART`, and `ST_RESTART` stays in `ST_RESTART`.
- On a STOP, `ST_IDLE`, `ST_HELD` and `ST_RESTART` go to `ST_FREED`.
- Any state goes to `ST_IDLE` when the block is disabled.

Top module: `i2c_bus_watch`

## Requirements
- R1: Reset and a low `en` clear `start_seen`, `stop_seen`, `restarted`, `irq_flag`, `bcl_flag` and `bcl_phase`.
- R2: A START (SDA falls while SCL is high) sets `start_seen` to 1 and `stop_seen` to 0. A STOP (SDA rises while SCL is high) sets `stop_seen` to 1 and clears `start_seen` and `restarted`.
- R3: `bus_free` is 1 when `stop_seen` is 1, or when `start_seen` and `stop_seen` are both 0, and is 0 otherwise.
- R4: `irq_flag` is set by a START, a repeated START, a STOP, a `byte_done` pulse or an `ack_done` pulse. `irq` equals `irq_flag` AND `irq_en`, so a STOP on a busy bus with `irq_en` high raises `irq`.
- R5: A START detected while `start_seen` is already 1 is a repeated START and sets `restarted`, with `start_seen` staying 1.
- R6: On an SCL rising edge, with `phase` not 0, `drv_sda` at 1 and sampled SDA at 0, `bcl_flag` is set. No collision is flagged when `phase` is 0 or `drv_sda` is 0.
- R7: `bcl_phase` holds the phase of the first collision since the last clear. The phase codes are 1 START, 2 repeated START, 3 address, 4 data, 5 acknowledge and 0 none.
- R8: `irq_flag` and `bcl_flag` stay set until their clear strobe (`irq_clr`, `bcl_clr`) is high for a cycle. A set event in the same cycle as the clear wins.
- R9: While `en` is low, bus conditions and collisions are ignored, and no state is reconstructed when `en` returns high.
- R10: SCL and SDA pass through two synchroniser flops. A status bit changes on the third clock edge after a line change, not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| irq_en | input | 1 | Interrupt enable |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| drv_sda | input | 1 | SDA level the local master intends (1 = released) |
| phase | input | 3 | Local master bus phase code (R7) |
| byte_done | input | 1 | Pulse: byte sent or received |
| ack_done | input | 1 | Pulse: acknowledge sent |
| irq_clr | input | 1 | One-cycle clear of `irq_flag` |
| bcl_clr | input | 1 | One-cycle clear of `bcl_flag` and `bcl_phase` |
| start_seen | output | 1 | Sticky START status |
| stop_seen | output | 1 | Sticky STOP status |
| restarted | output | 1 | Repeated START seen in the current transfer |
| bus_free | output | 1 | Local master may take the bus |
| irq_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Gated interrupt |
| bcl_flag | output | 1 | Sticky bus-collision flag |
| bcl_phase | output | 3 | Phase of the first collision |

## Verification
The condition detector is driven with line sequences in which only one line moves per step. This separates a START from a repeated START and from a STOP, and separates those from plain SCL or SDA toggles that must leave the state alone. The collision detector is tried in each of the five phases, then with the line released, with the master driving low, and with no phase active, so that a real loss can be told apart from the two cases that must be ignored. A second loss without a clear shows whether the first phase is kept. Timing tests sample one cycle before and at the expected edge to show the synchroniser depth, and a clear strobe is pulsed in the same cycle as a set event.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

    localparam int PHASE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HELD    = 2'd1,
        ST_RESTART = 2'd2,
        ST_FREED   = 2'd3
    } bus_state_t;

    typedef enum logic [PHASE_W-1:0] {
        PH_NONE   = 3'd0,
        PH_START  = 3'd1,
        PH_RSTART = 3'd2,
        PH_ADDR   = 3'd3,
        PH_DATA   = 3'd4,
        PH_ACK    = 3'd5
    } bus_phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES    = 2,
    parameter int NUM_LINES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] din,
    output logic [NUM_LINES-1:0] dsync,
    output logic [NUM_LINES-1:0] dprev
);

    localparam int TOP = STAGES - 1;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain    <= '1;
                dprev[i] <= 1'b1;
            end else begin
                chain    <= {chain[TOP-1:0], din[i]};
                dprev[i] <= chain[TOP];
            end
        end

        assign dsync[i] = chain[TOP];
    end

endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
    import i2c_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_s,
    input  logic scl_q,
    input  logic sda_s,
    input  logic sda_q,
    output logic start_evt,
    output logic rstart_evt,
    output logic stop_evt,
    output logic start_seen,
    output logic stop_seen,
    output logic restarted,
    output logic bus_free
);

    bus_state_t state, state_nx;
    logic scl_hi;

    assign scl_hi    = scl_s && scl_q;
    assign start_evt = en && scl_hi && sda_q && !sda_s;
    assign stop_evt  = en && scl_hi && !sda_q && sda_s;

    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_FREED: begin
                    if (start_evt)     state_nx = ST_HELD;
                    else if (stop_evt) state_nx = ST_FREED;
                end
                ST_HELD, ST_RESTART: begin
                    if (start_evt)     state_nx = ST_RESTART;
                    else if (stop_evt) state_nx = ST_FREED;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        start_seen = 1'b0;
        stop_seen  = 1'b0;
        restarted  = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_HELD:    start_seen = 1'b1;
            ST_RESTART: begin
                start_seen = 1'b1;
                restarted  = 1'b1;
            end
            ST_FREED:   stop_seen = 1'b1;
            default:    ;
        endcase
        bus_free   = !start_seen;
        rstart_evt = start_evt && start_seen;
    end

    p_start_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start_evt) |=> (start_seen && !stop_seen));

    p_stop_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stop_evt) |=> (stop_seen && !start_seen && !restarted));

    p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!start_seen && !stop_seen && !restarted));

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start_evt && start_seen) |=> restarted);

endmodule

// File: rtl/i2c_arb_check.sv
module i2c_arb_check
    import i2c_mon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               scl_s,
    input  logic               scl_q,
    input  logic               sda_s,
    input  logic               drv_sda,
    input  logic [PHASE_W-1:0] phase,
    input  logic               clr,
    output logic               bcl_flag,
    output logic [PHASE_W-1:0] bcl_phase
);

    logic scl_rise, lost;

    assign scl_rise = scl_s && !scl_q;
    assign lost     = en && scl_rise && (phase != PH_NONE) && drv_sda && !sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcl_flag  <= 1'b0;
            bcl_phase <= PH_NONE;
        end else if (!en) begin
            bcl_flag  <= 1'b0;
            bcl_phase <= PH_NONE;
        end else if (lost) begin
            bcl_flag <= 1'b1;
            if (!bcl_flag || clr) bcl_phase <= phase;
        end else if (clr) begin
            bcl_flag  <= 1'b0;
            bcl_phase <= PH_NONE;
        end
    end

    p_bcl_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bcl_flag && !clr) |=> bcl_flag);

    p_loss_needs_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcl_flag) |-> ($past(phase) != PH_NONE && $past(drv_sda)));

    p_first_phase_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bcl_flag && !clr) |=> $stable(bcl_phase));

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               irq_en,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               drv_sda,
    input  logic [PHASE_W-1:0] phase,
    input  logic               byte_done,
    input  logic               ack_done,
    input  logic               irq_clr,
    input  logic               bcl_clr,
    output logic               start_seen,
    output logic               stop_seen,
    output logic               restarted,
    output logic               bus_free,
    output logic               irq_flag,
    output logic               irq,
    output logic               bcl_flag,
    output logic [PHASE_W-1:0] bcl_phase
);

    localparam int LINES = 2;
    localparam int L_SCL = 1;
    localparam int L_SDA = 0;

    logic [LINES-1:0] lines_s, lines_q;
    logic start_evt, rstart_evt, stop_evt, irq_set;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .NUM_LINES(LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_in, sda_in}),
        .dsync (lines_s),
        .dprev (lines_q)
    );

    i2c_cond_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .scl_s      (lines_s[L_SCL]),
        .scl_q      (lines_q[L_SCL]),
        .sda_s      (lines_s[L_SDA]),
        .sda_q      (lines_q[L_SDA]),
        .start_evt  (start_evt),
        .rstart_evt (rstart_evt),
        .stop_evt   (stop_evt),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .restarted  (restarted),
        .bus_free   (bus_free)
    );

    i2c_arb_check u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .scl_s     (lines_s[L_SCL]),
        .scl_q     (lines_q[L_SCL]),
        .sda_s     (lines_s[L_SDA]),
        .drv_sda   (drv_sda),
        .phase     (phase),
        .clr       (bcl_clr),
        .bcl_flag  (bcl_flag),
        .bcl_phase (bcl_phase)
    );

    assign irq_set = en && (start_evt || rstart_evt || stop_evt || byte_done || ack_done);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_flag <= 1'b0;
        else if (!en)     irq_flag <= 1'b0;
        else if (irq_set) irq_flag <= 1'b1;
        else if (irq_clr) irq_flag <= 1'b0;
    end

    assign irq = irq_flag && irq_en;

    p_stop_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stop_evt && irq_en) |=> (irq_flag && (irq || !irq_en)));

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && irq_flag && !irq_clr) |=> irq_flag);

    p_free_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free == (stop_seen || (!start_seen && !stop_seen)));

endmodule

// File: tb/sim_i2c_bus_watch.sv
module sim_i2c_bus_watch;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, irq_en = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1, drv_sda = 1'b1;
    logic [2:0] phase = 3'd0;
    logic byte_done = 1'b0, ack_done = 1'b0, irq_clr = 1'b0, bcl_clr = 1'b0;
    logic start_seen, stop_seen, restarted, bus_free, irq_flag, irq, bcl_flag;
    logic [2:0] bcl_phase;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bus_watch u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .irq_en(irq_en),
        .scl_in(scl_in), .sda_in(sda_in), .drv_sda(drv_sda), .phase(phase),
        .byte_done(byte_done), .ack_done(ack_done), .irq_clr(irq_clr), .bcl_clr(bcl_clr),
        .start_seen(start_seen), .stop_seen(stop_seen), .restarted(restarted),
        .bus_free(bus_free), .irq_flag(irq_flag), .irq(irq),
        .bcl_flag(bcl_flag), .bcl_phase(bcl_phase)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus(input logic scl, input logic sda);
        @(negedge clk);
        scl_in = scl;
        sda_in = sda;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_irq_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_bcl_clr();
        @(negedge clk); bcl_clr = 1'b1;
        @(negedge clk); bcl_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 start_seen after reset", start_seen, 0);
        chk("R1 stop_seen after reset", stop_seen, 0);
        chk("R1 irq_flag after reset", irq_flag, 0);
        chk("R1 bcl_flag after reset", bcl_flag, 0);
        chk("R3 bus_free when idle", bus_free, 1);
    endtask

    task automatic t_start_latency();
        @(negedge clk);
        sda_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 start_seen after two edges", start_seen, 0);
        @(negedge clk);
        chk("R10 start_seen after three edges", start_seen, 1);
        repeat (2) @(negedge clk);
        chk("R2 stop_seen after START", stop_seen, 0);
        chk("R3 bus_free while held", bus_free, 0);
        chk("R4 irq_flag on START", irq_flag, 1);
        chk("R4 irq gated by irq_en low", irq, 0);
        chk("R5 restarted after first START", restarted, 0);
    endtask

    task automatic t_repeated_start();
        pulse_irq_clr();
        chk("R8 irq_flag cleared", irq_flag, 0);
        bus(1'b0, 1'b0);
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        chk("R2 SCL toggle keeps state", restarted, 0);
        bus(1'b1, 1'b0);
        chk("R5 restarted on repeated START", restarted, 1);
        chk("R5 start_seen stays", start_seen, 1);
        chk("R4 irq_flag on repeated START", irq_flag, 1);
    endtask

    task automatic t_stop_irq();
        pulse_irq_clr();
        irq_en = 1'b1;
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        chk("R4 irq quiet before STOP", irq, 0);
        bus(1'b1, 1'b1);
        chk("R2 stop_seen on STOP", stop_seen, 1);
        chk("R2 start_seen cleared by STOP", start_seen, 0);
        chk("R2 restarted cleared by STOP", restarted, 0);
        chk("R3 bus_free after STOP", bus_free, 1);
        chk("R4 irq raised by STOP", irq, 1);
        irq_en = 1'b0;
    endtask

    task automatic t_byte_ack();
        pulse_irq_clr();
        @(negedge clk); byte_done = 1'b1;
        @(negedge clk); byte_done = 1'b0;
        chk("R4 irq_flag on byte_done", irq_flag, 1);
        pulse_irq_clr();
        @(negedge clk); ack_done = 1'b1;
        @(negedge clk); ack_done = 1'b0;
        chk("R4 irq_flag on ack_done", irq_flag, 1);
        @(negedge clk); byte_done = 1'b1; irq_clr = 1'b1;
        @(negedge clk); byte_done = 1'b0; irq_clr = 1'b0;
        chk("R8 set wins over clear", irq_flag, 1);
    endtask

    task automatic t_collision_phases();
        for (int ph = 1; ph <= 5; ph++) begin
            pulse_bcl_clr();
            bus(1'b0, 1'b0);
            phase = 3'(ph);
            drv_sda = 1'b1;
            bus(1'b1, 1'b0);
            chk($sformatf("R6 bcl_flag in phase %0d", ph), bcl_flag, 1);
            chk("R7 bcl_phase code", bcl_phase, ph);
            phase = 3'd0;
        end
    endtask

    task automatic t_no_collision();
        pulse_bcl_clr();
        chk("R8 bcl_flag cleared", bcl_flag, 0);
        bus(1'b0, 1'b0);
        phase = 3'd4; drv_sda = 1'b0;
        bus(1'b1, 1'b0);
        chk("R6 no loss while driving low", bcl_flag, 0);
        bus(1'b0, 1'b0);
        phase = 3'd0; drv_sda = 1'b1;
        bus(1'b1, 1'b0);
        chk("R6 no loss with no phase", bcl_flag, 0);
        bus(1'b0, 1'b0);
        bus(1'b0, 1'b1);
        phase = 3'd4;
        bus(1'b1, 1'b1);
        chk("R6 no loss when SDA matches", bcl_flag, 0);
        bus(1'b0, 1'b1);
        bus(1'b0, 1'b0);
        phase = 3'd3;
        bus(1'b1, 1'b0);
        bus(1'b0, 1'b0);
        phase = 3'd4;
        bus(1'b1, 1'b0);
        chk("R8 bcl_flag still set", bcl_flag, 1);
        chk("R7 first loss phase kept", bcl_phase, 3);
        phase = 3'd0;
    endtask

    task automatic t_disable();
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        bus(1'b1, 1'b0);
        chk("R2 START before disable", start_seen, 1);
        @(negedge clk); en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 start_seen cleared by disable", start_seen, 0);
        chk("R1 irq_flag cleared by disable", irq_flag, 0);
        chk("R1 bcl_flag cleared by disable", bcl_flag, 0);
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        bus(1'b1, 1'b0);
        chk("R9 START ignored while disabled", start_seen, 0);
        chk("R9 irq_flag quiet while disabled", irq_flag, 0);
        @(negedge clk); en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 no state rebuilt on enable", start_seen, 0);
        bus(1'b1, 1'b1);
        chk("R2 STOP after re-enable", stop_seen, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_start_latency();
        t_repeated_start();
        t_stop_irq();
        t_byte_ack();
        t_collision_phases();
        t_no_collision();
        t_disable();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule